// File: doc/BRIEF.md
# Bidirectional Block Mover

This engine copies a block of words in memory. Three registers describe the block: a signed word count, a source address and a destination address. The sign of the count sets the direction. A positive count copies upward from the given addresses. A negative count copies downward, and in that case both addresses point one word above the first word touched. A zero count finishes at once.

When the operation is accepted, the engine writes the final values into the three registers straight away: both addresses are advanced by the whole count and the count becomes zero. The engine keeps the direction internally. When an interrupt request stops the copy between words, it rebuilds the three registers from the words still outstanding, with a correction that depends on the direction. Issuing the operation again from those register values then finishes the block.

A forward copy whose destination is exactly one word above its source replicates the first source word through the block. The engine handles it with one load followed by a store-only loop. The memory port is a plain word-wide port: read data is returned the cycle after a read strobe, and a loaded word is held for one extra cycle before it is stored.

Top module: `block_mover`

## Requirements
- R1: A start with a count of zero raises `done` in the following cycle, makes no memory access, and leaves the source and destination registers unchanged with the count register at zero.
- R2: A positive count N copies the word at source+i to destination+i for i = 0..N-1, in increasing address order.
- R3: A negative count -M copies the word at source-1-i to destination-1-i for i = 0..M-1, in decreasing address order.
- R4: In the cycle after a non-zero start, `busy` is high, the count register reads zero, and the source and destination registers read their start values plus the count. They stay that way until the block completes.
- R5: `irq` is sampled only in a cycle where a load other than the first would be issued, or where a fill store other than the first would be issued. If it is high, that cycle makes no memory access and `frozen` rises in the next cycle. At least one word always moves.
- R6: After a forward copy is frozen with k words moved, the registers read count N-k, source start+k and destination start+k.
- R7: After a backward copy is frozen with k words moved, the registers read count -M+k, source start-k and destination start-k.
- R8: Re-issuing the operation from the frozen register values completes the block. The resulting memory contents equal those of an uninterrupted run.
- R9: A positive count with destination equal to source+1 issues exactly one read and then N writes of that word to destination..destination+N-1. A negative count with the same address relation uses the normal copy with M reads.
- R10: Read data arrives the cycle after `mem_rd`, and a word is stored two cycles after its load. A normal copy takes 3 cycles per word, so `done` follows start by 3N+1 cycles. A fill takes N+3 cycles. A freeze after k copied words comes 3k+2 cycles after start, or k+4 cycles in a fill.
- R11: `done` and `frozen` are single-cycle pulses followed by `busy` low. All address and count arithmetic is 30-bit two's complement and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| cnt_i | input | 30 | Signed word count of the new operation |
| src_i | input | 30 | Source address of the new operation |
| dst_i | input | 30 | Destination address of the new operation |
| irq | input | 1 | Interrupt request |
| cnt_o | output | 30 | Count register |
| src_o | output | 30 | Source address register |
| dst_o | output | 30 | Destination address register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the block completes |
| frozen | output | 1 | One-cycle pulse when an interrupt stops the block |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 30 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
The register commit is due one cycle after the start edge. `done` is due 3N+1 cycles after that edge for a normal copy, N+3 for a fill and 1 for a zero count. `frozen` is due 3k+2 cycles after it, or k+4 in a fill. The bench samples on falling edges and counts those edges from the start edge, so every pulse is compared against the exact cycle the formulas give. It raises `irq` on the falling edge after the k-th store is counted, so the request lands in the next load or fill-store cycle. Memory is compared against a sequential copy model after each freeze and each completion.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOAD  = 3'd1,
        S_WAIT  = 3'd2,
        S_STORE = 3'd3,
        S_FILL  = 3'd4
    } bm_state_e;
endpackage

// File: rtl/bm_step.sv
module bm_step #(
    parameter int W = 30
) (
    input  logic [W-1:0] a,
    input  logic         down,
    output logic [W-1:0] y
);
    always_comb y = down ? a - W'(1) : a + W'(1);
endmodule

// File: rtl/bm_restore.sv
module bm_restore #(
    parameter int W = 30
) (
    input  logic         fwd,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] src_fin,
    input  logic [W-1:0] dst_fin,
    output logic [W-1:0] cnt_r,
    output logic [W-1:0] src_r,
    output logic [W-1:0] dst_r
);
    always_comb begin
        // signed count still outstanding, rebuilt from the saved direction
        cnt_r = fwd ? rem : W'(0) - rem;
        src_r = src_fin - cnt_r;
        dst_r = dst_fin - cnt_r;
    end
endmodule

// File: rtl/block_mover.sv
module block_mover
    import bm_pkg::*;
#(
    parameter int AW = 30,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cnt_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          irq,
    output logic [AW-1:0] cnt_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          busy,
    output logic          done,
    output logic          frozen,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int MSB = AW - 1;

    typedef struct packed {
        bm_state_e     st;
        logic [AW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] sp;
        logic [AW-1:0] dp;
        logic [AW-1:0] rem;
        logic          fwd;
        logic          fill;
        logic          first;
        logic          done;
        logic          frz;
        logic [DW-1:0] data;
    } bm_reg_t;

    bm_reg_t r_q, r_d;

    logic [AW-1:0] sp_nx, dp_nx;
    logic [AW-1:0] cnt_rs, src_rs, dst_rs;

    bm_step #(.W(AW)) u_step_src (.a(r_q.sp), .down(!r_q.fwd), .y(sp_nx));
    bm_step #(.W(AW)) u_step_dst (.a(r_q.dp), .down(!r_q.fwd), .y(dp_nx));

    bm_restore #(.W(AW)) u_restore (
        .fwd    (r_q.fwd),
        .rem    (r_q.rem),
        .src_fin(r_q.src),
        .dst_fin(r_q.dst),
        .cnt_r  (cnt_rs),
        .src_r  (src_rs),
        .dst_r  (dst_rs)
    );

    logic          neg_in;
    logic [AW-1:0] mag_in;
    always_comb begin
        neg_in = cnt_i[MSB];
        mag_in = neg_in ? AW'(0) - cnt_i : cnt_i;
    end

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.frz   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = r_q.data;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.fwd   = !neg_in;
                    r_d.cnt   = '0;
                    r_d.src   = src_i + cnt_i;
                    r_d.dst   = dst_i + cnt_i;
                    r_d.rem   = mag_in;
                    r_d.sp    = neg_in ? src_i - AW'(1) : src_i;
                    r_d.dp    = neg_in ? dst_i - AW'(1) : dst_i;
                    r_d.fill  = !neg_in && (dst_i == src_i + AW'(1));
                    r_d.first = 1'b1;
                    if (cnt_i == '0) r_d.done = 1'b1;
                    else             r_d.st   = S_LOAD;
                end
            end
            S_LOAD: begin
                if (!r_q.first && irq) begin
                    r_d.frz = 1'b1;
                    r_d.st  = S_IDLE;
                    r_d.cnt = cnt_rs;
                    r_d.src = src_rs;
                    r_d.dst = dst_rs;
                end else begin
                    mem_rd    = 1'b1;
                    mem_addr  = r_q.sp;
                    r_d.sp    = sp_nx;
                    r_d.first = 1'b0;
                    r_d.st    = S_WAIT;
                end
            end
            S_WAIT: begin
                r_d.data = mem_rdata;
                r_d.st   = S_STORE;
            end
            S_STORE, S_FILL: begin
                if (r_q.st == S_FILL && irq) begin
                    r_d.frz = 1'b1;
                    r_d.st  = S_IDLE;
                    r_d.cnt = cnt_rs;
                    r_d.src = src_rs;
                    r_d.dst = dst_rs;
                end else begin
                    mem_wr   = 1'b1;
                    mem_addr = r_q.dp;
                    r_d.dp   = dp_nx;
                    r_d.rem  = r_q.rem - AW'(1);
                    if (r_q.rem == AW'(1)) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st = r_q.fill ? S_FILL : S_LOAD;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cnt_o  = r_q.cnt;
        src_o  = r_q.src;
        dst_o  = r_q.dst;
        busy   = (r_q.st != S_IDLE);
        done   = r_q.done;
        frozen = r_q.frz;
    end

    // R4: the count register reads zero for the whole operation
    p_cnt_zero_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_o == '0));

    // R10: a word is never stored in the cycle right after its load
    p_load_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_wr);

    // R11: status pulses last one cycle and the engine is idle after them
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || frozen) |-> (!busy && !(done && frozen)) ##1 (!done && !frozen));

    // R5: the freeze cycle made no memory access
    p_frz_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> $past(!mem_rd && !mem_wr));

    // R1: a completion that follows an idle cycle belongs to a zero count and leaves the count at zero
    p_zero_quick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!busy)) |-> (cnt_o == '0));

    // R9: a fill loop never reads
    p_fill_noread_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FILL) |-> !mem_rd);

    // R11: the engine never reads and writes in the same cycle
    p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/tb_block_mover.sv
module tb_block_mover;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int MW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cnt_i = '0, src_i = '0, dst_i = '0;
    logic          irq = 1'b0;
    logic [AW-1:0] cnt_o, src_o, dst_o, mem_addr;
    logic          busy, done, frozen, mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;   // 50 MHz

    block_mover #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_i(cnt_i), .src_i(src_i),
        .dst_i(dst_i), .irq(irq), .cnt_o(cnt_o), .src_o(src_o), .dst_o(dst_o),
        .busy(busy), .done(done), .frozen(frozen), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [DW-1:0] mem [MW];
    logic [DW-1:0] shadow [MW];
    int wr_cnt = 0;
    int rd_cnt = 0;

    initial for (int i = 0; i < MW; i++) begin
        mem[i]    = 32'hC0DE_0000 + 32'(i);
        shadow[i] = 32'hC0DE_0000 + 32'(i);
    end

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [AW-1:0] c;
        logic [AW-1:0] s;
        logic [AW-1:0] d;
        logic [7:0]    k;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{30'd5,          30'd10,         30'd40,  8'd0},  // R2 forward
        '{30'h3FFFFFFC,   30'd80,         30'd120, 8'd0},  // R3 backward, -4
        '{30'd6,          30'd20,         30'd21,  8'd0},  // R9 fill
        '{30'd7,          30'd50,         30'd140, 8'd3},  // R6 forward frozen
        '{30'h3FFFFFFA,   30'd200,        30'd180, 8'd2},  // R7 backward frozen, -6
        '{30'd5,          30'd60,         30'd61,  8'd2},  // R9 fill frozen
        '{30'd3,          30'd30,         30'd28,  8'd0},  // R2 overlapping downward move
        '{30'd4,          30'h3FFFFFFE,   30'd100, 8'd0},  // R11 wrapping source
        '{30'h3FFFFFFD,   30'd90,         30'd91,  8'd0}   // R9 backward with dst=src+1, -3
    };

    task automatic run_op(input logic [AW-1:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input int k, input bit pre, output bit froze);
        bit fwd, fill, exp_frz;
        logic [AW-1:0] m, adv;
        int kk, w, cyc, wr0, rd0, exp_cyc, bad_words;
        fwd  = !c[AW-1];
        m    = fwd ? c : AW'(0) - c;
        fill = (c != '0) && fwd && (d == s + AW'(1));
        kk   = pre ? 1 : k;
        exp_frz = (kk != 0) && (AW'(kk) < m);
        w    = exp_frz ? kk : int'(m);
        wr0  = wr_cnt;
        rd0  = rd_cnt;

        @(negedge clk);
        start = 1'b1; cnt_i = c; src_i = s; dst_i = d; irq = pre;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (c == '0) begin
            chk(done == 1'b1, "R1 done after zero count", 64'(done), 64'd1);
        end else begin
            chk(busy && cnt_o == '0 && src_o == s + c && dst_o == d + c, "R4 registers committed at start",
                {src_o, 4'h0, cnt_o}, {s + c, 4'h0, 30'd0});
        end
        while (!(done || frozen) && cyc < 2000) begin
            if (k != 0 && (wr_cnt - wr0) >= k) irq = 1'b1;
            @(negedge clk);
            cyc++;
        end
        froze = frozen;
        irq = 1'b0;

        if (m == '0)      exp_cyc = 1;
        else if (exp_frz) exp_cyc = fill ? w + 4 : 3 * w + 2;
        else              exp_cyc = fill ? w + 3 : 3 * w + 1;
        chk(frozen == exp_frz && done == !exp_frz, "R5 end kind (frozen vs done)", 64'(frozen), 64'(exp_frz));
        chk(cyc == exp_cyc, "R10 cycles from start to status pulse", 64'(cyc), 64'(exp_cyc));

        adv = fwd ? AW'(w) : AW'(0) - AW'(w);
        chk(cnt_o == c - adv, fwd ? "R6 count register" : "R7 count register", 64'(cnt_o), 64'(c - adv));
        chk(src_o == s + adv && dst_o == d + adv, fwd ? "R6 address registers" : "R7 address registers",
            {src_o, 4'h0, dst_o}, {s + adv, 4'h0, d + adv});
        chk((wr_cnt - wr0) == w, "R2/R3 number of stores", 64'(wr_cnt - wr0), 64'(w));
        chk((rd_cnt - rd0) == ((m == '0) ? 0 : (fill ? 1 : w)), "R9 number of loads",
            64'(rd_cnt - rd0), 64'((m == '0) ? 0 : (fill ? 1 : w)));

        for (int i = 0; i < w; i++) begin
            if (fwd) shadow[8'(d + AW'(i))] = shadow[8'(s + AW'(i))];
            else     shadow[8'(d - AW'(1) - AW'(i))] = shadow[8'(s - AW'(1) - AW'(i))];
        end
        bad_words = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== shadow[i]) bad_words++;
        chk(bad_words == 0, fwd ? "R2 memory contents" : "R3 memory contents", 64'(bad_words), 64'd0);

        @(negedge clk);
        chk(!done && !frozen && !busy, "R11 single-cycle status pulse", {done, frozen, busy}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !frozen && !mem_rd && !mem_wr, "R11 quiet in reset",
            {busy, done, frozen, mem_rd, mem_wr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt_o == '0 && src_o == '0 && dst_o == '0 && !busy, "R4 register reset values",
            {cnt_o, src_o}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            bit fz;
            run_op(VEC[v].c, VEC[v].s, VEC[v].d, int'(VEC[v].k), 1'b0, fz);
            // R8: resume from the frozen register values
            if (fz) begin
                bit fz2;
                run_op(cnt_o, src_o, dst_o, 0, 1'b0, fz2);
                chk(!fz2, "R8 resumed block completes", 64'(fz2), 64'd0);
            end
        end

        begin
            // R1: zero count, no access, registers keep the given values
            bit fz;
            run_op(30'd0, 30'd33, 30'd77, 0, 1'b0, fz);
            chk(src_o == 30'd33 && dst_o == 30'd77, "R1 registers unchanged", {src_o, 4'h0, dst_o},
                {30'd33, 4'h0, 30'd77});
        end

        begin
            // R5: interrupt already pending at start, first word still moves
            bit fz, fz2;
            run_op(30'd4, 30'd150, 30'd10, 0, 1'b1, fz);
            chk(fz, "R5 pending interrupt freezes after first word", 64'(fz), 64'd1);
            run_op(cnt_o, src_o, dst_o, 0, 1'b0, fz2);
            chk(!fz2, "R8 resume after early freeze", 64'(fz2), 64'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule